// File: doc/BRIEF.md
# Address Window Switch Controller

This block points a host-visible address window at one of several on-chip cores before letting an access through. Each access request names a target core, a direction, a width (8, 16 or 32 bits) and an offset inside that core's region. The block remembers which core the window currently points at. If the request names that core, the access goes straight to the core port. If not, the block first moves the window and checks that the move took effect.

To move the window, the block writes the window register with the enumeration base plus the core index shifted left by the region size exponent. It then reads the register back and recovers the index by subtracting the base and shifting right. If the recovered index differs from the requested one, the block waits a fixed 10 microseconds, counted in clock cycles, and writes again. Once the attempt counter has run past the retry limit it gives up. A read that gives up returns all ones at its own width, and a write that gives up is dropped.

For test, a per-request fault count makes that many of the first window writes of the switch land on a neighbouring core, which forces the retry path. Requests enter on a valid/ready pair. `req_ready` is high only while the block is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. Requests offered while the block is busy are simply not taken. The response is a single-cycle `rsp_valid` pulse and cannot be held off.

Top module: `win_switch_ctrl`

## Requirements
- R1: After a successful switch, `win_base` equals ENUM_BASE + (core index << REGION_LOG2).
- R2: A request to the currently mapped core performs no switch and ignores `req_fault`. Its response pulse comes at the first rising edge after the acceptance edge.
- R3: A switch that succeeds after k mismatching write-backs (k = number of leading faulty writes) responds at edge 2(k+1) + k·WAIT_CYC + 1 after acceptance. WAIT_CYC = CLK_MHZ·WAIT_US cycles separate a mismatching read-back from the next window write.
- R4: A switch fails after MAX_RETRY+2 mismatching attempts, with its response at edge 2(MAX_RETRY+2) + (MAX_RETRY+1)·WAIT_CYC after acceptance and `rsp_err`=1. A failed read returns all ones at its width. A failed write never raises `core_en`.
- R5: The mapped-core record changes only on a successful switch. After a failed switch, a request to the previously mapped core is still a hit.
- R6: `req_ready` is low from the acceptance edge until the response edge, and requests offered during that time are not taken.
- R7: Read data is formatted by size code: 0 gives bits [7:0], 1 gives bits [15:0], 2 gives all 32 bits, and the unused upper bits are zero. Writes respond with zero data.
- R8: Each completed access raises `core_en` for exactly one cycle. During that cycle `core_sel` is the mapped core, and `core_addr`, `core_size`, `core_we` and `core_wdata` carry the request's fields.
- R9: After reset, `req_ready`=1, `rsp_valid`=0 and `win_base`=ENUM_BASE, and no core counts as mapped, so the first request always switches.
- R10: `rsp_valid` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; request taken when both high |
| req_core | input | IDX_W | Target core index |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Width code: 0 = 8, 1 = 16, 2 = 32 bits |
| req_off | input | REGION_LOG2 | Offset inside the core region |
| req_wdata | input | 32 | Write data |
| req_fault | input | FLT_W | Test: number of leading window writes that land on a wrong core |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Switch failed |
| rsp_rdata | output | 32 | Read data, or all ones at width on failure |
| core_en | output | 1 | Access strobe to the mapped core |
| core_we | output | 1 | Access direction |
| core_sel | output | IDX_W | Core being accessed |
| core_size | output | 2 | Access width code |
| core_addr | output | REGION_LOG2 | Offset in the region |
| core_wdata | output | 32 | Write data to the core |
| core_rdata | input | 32 | Read data from the core, same cycle as `core_en` |
| win_base | output | ADDR_W | Current window register value |

## Verification
The hardest situation to reach is the retry-limit boundary. A switch must mismatch on exactly MAX_RETRY+1 attempts and still succeed on the next one, while one more mismatch must turn it into a failure. The fault-count input places the stimulus on each side of that boundary, and the reference model predicts the exact response edge from the fault count. A long switch is also held with a competing request on the input throughout, to show that nothing is taken while busy. A failed switch is followed by a request to the old core, to show that the mapping record survived.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_RB,
    ST_WT,
    ST_ACC
  } wsc_state_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
endpackage

// File: rtl/wsc_window_reg.sv
module wsc_window_reg #(
  parameter int ADDR_W = 32,
  parameter int IDX_W = 3,
  parameter int REGION_LOG2 = 12,
  parameter logic [ADDR_W-1:0] ENUM_BASE = 'h1800_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_corrupt,
  output logic [ADDR_W-1:0] win_q,
  output logic [IDX_W-1:0]  rd_idx
);
  logic [IDX_W-1:0]  tgt_idx;
  logic [ADDR_W-1:0] wr_val;
  logic [ADDR_W-1:0] diff;

  // a corrupted write lands on the neighbouring core
  assign tgt_idx = wr_corrupt ? (wr_idx ^ IDX_W'(1)) : wr_idx;
  assign wr_val  = ENUM_BASE + (ADDR_W'(tgt_idx) << REGION_LOG2);

  always_ff @(posedge clk) begin
    if (!rst_n) win_q <= ENUM_BASE;
    else if (wr_en) win_q <= wr_val;
  end

  assign diff   = win_q - ENUM_BASE;
  assign rd_idx = IDX_W'(diff >> REGION_LOG2);

  AST_CLEAN_WRITE_READS_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_corrupt) |=> (rd_idx == $past(wr_idx))); // R1
endmodule

// File: rtl/wsc_wait_timer.sv
module wsc_wait_timer #(
  parameter int WAIT_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);
  localparam int CNT_W = $clog2(WAIT_CYC + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (load) cnt <= CNT_W'(WAIT_CYC - 1);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  AST_WAIT_NOT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!done || WAIT_CYC == 1)); // R3
endmodule

// File: rtl/wsc_width_fmt.sv
module wsc_width_fmt
  import wsc_pkg::*;
(
  input  logic [1:0]        size,
  input  logic              use_ones,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] fmt
);
  logic [DATA_W-1:0] src;

  assign src = use_ones ? '1 : data;

  always_comb begin
    case (size)
      SZ_BYTE: fmt = {{(DATA_W-8){1'b0}}, src[7:0]};
      SZ_HALF: fmt = {{(DATA_W-16){1'b0}}, src[15:0]};
      default: fmt = src;
    endcase
  end
endmodule

// File: rtl/win_switch_ctrl.sv
module win_switch_ctrl
  import wsc_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int REGION_LOG2 = 12,
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] ENUM_BASE = 'h1800_0000,
  parameter int MAX_RETRY = 3,
  parameter int CLK_MHZ = 10,
  parameter int WAIT_US = 10,
  parameter int FLT_W = 4,
  localparam int IDX_W = $clog2(NUM_CORES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [IDX_W-1:0]       req_core,
  input  logic                   req_we,
  input  logic [1:0]             req_size,
  input  logic [REGION_LOG2-1:0] req_off,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic [FLT_W-1:0]       req_fault,
  output logic                   rsp_valid,
  output logic                   rsp_err,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic                   core_en,
  output logic                   core_we,
  output logic [IDX_W-1:0]       core_sel,
  output logic [1:0]             core_size,
  output logic [REGION_LOG2-1:0] core_addr,
  output logic [DATA_W-1:0]      core_wdata,
  input  logic [DATA_W-1:0]      core_rdata,
  output logic [ADDR_W-1:0]      win_base
);
  localparam int WAIT_CYC = CLK_MHZ * WAIT_US;
  localparam int ATT_W = $clog2(MAX_RETRY + 2) + 1;

  wsc_state_t             st;
  logic [IDX_W-1:0]       r_core;
  logic                   r_we;
  logic [1:0]             r_size;
  logic [REGION_LOG2-1:0] r_off;
  logic [DATA_W-1:0]      r_wdata;
  logic [FLT_W-1:0]       flt_left;
  logic [ATT_W-1:0]       att;
  logic [IDX_W-1:0]       map_idx;
  logic                   map_vld;

  logic                   accept;
  logic                   hit;
  logic                   match;
  logic                   give_up;
  logic                   tmr_load;
  logic                   tmr_done;
  logic [IDX_W-1:0]       rb_idx;
  logic [DATA_W-1:0]      fmt_data;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign hit       = map_vld && (map_idx == req_core);
  assign match     = (rb_idx == r_core);
  assign give_up   = (att > ATT_W'(MAX_RETRY));
  assign tmr_load  = (st == ST_RB) && !match && !give_up;

  wsc_window_reg #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .REGION_LOG2(REGION_LOG2), .ENUM_BASE(ENUM_BASE)
  ) u_win (
    .clk(clk), .rst_n(rst_n),
    .wr_en(st == ST_WR), .wr_idx(r_core), .wr_corrupt(flt_left != '0),
    .win_q(win_base), .rd_idx(rb_idx)
  );

  wsc_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .done(tmr_done)
  );

  wsc_width_fmt u_fmt (
    .size(r_size), .use_ones(st != ST_ACC), .data(core_rdata), .fmt(fmt_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      r_core    <= '0;
      r_we      <= 1'b0;
      r_size    <= '0;
      r_off     <= '0;
      r_wdata   <= '0;
      flt_left  <= '0;
      att       <= '0;
      map_idx   <= '0;
      map_vld   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            r_core   <= req_core;
            r_we     <= req_we;
            r_size   <= req_size;
            r_off    <= req_off;
            r_wdata  <= req_wdata;
            flt_left <= req_fault;
            att      <= '0;
            st       <= hit ? ST_ACC : ST_WR;
          end
        end
        ST_WR: begin
          if (flt_left != '0) flt_left <= flt_left - 1'b1;
          st <= ST_RB;
        end
        ST_RB: begin
          if (match) begin
            map_idx <= r_core;
            map_vld <= 1'b1;
            st      <= ST_ACC;
          end else if (give_up) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b1;
            rsp_rdata <= r_we ? '0 : fmt_data;
            st        <= ST_IDLE;
          end else begin
            att <= att + 1'b1;
            st  <= ST_WT;
          end
        end
        ST_WT: begin
          if (tmr_done) st <= ST_WR;
        end
        ST_ACC: begin
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b0;
          rsp_rdata <= r_we ? '0 : fmt_data;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign core_en    = (st == ST_ACC);
  assign core_we    = r_we;
  assign core_sel   = r_core;
  assign core_size  = r_size;
  assign core_addr  = r_off;
  assign core_wdata = r_wdata;

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10
  AST_BUSY_DURING_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    core_en |-> !req_ready); // R6
  AST_FAIL_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (att == ATT_W'(MAX_RETRY + 1))); // R4
  AST_ACCESS_TO_MAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    core_en |-> (map_vld && map_idx == core_sel)); // R8
  AST_MAP_HELD_ON_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RB && !match) |=> ($stable(map_idx) && $stable(map_vld))); // R5
endmodule

// File: tb/sim_win_switch_ctrl.sv
module sim_win_switch_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int W = 100;
  localparam int MAXR = 3;
  localparam logic [31:0] EBASE = 32'h1800_0000;
  localparam int RL = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_core = '0;
  logic req_we = 1'b0;
  logic [1:0] req_size = '0;
  logic [RL-1:0] req_off = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0] req_fault = '0;
  logic rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic core_en, core_we;
  logic [2:0] core_sel;
  logic [1:0] core_size;
  logic [RL-1:0] core_addr;
  logic [31:0] core_wdata, core_rdata;
  logic [31:0] win_base;

  int checks = 0;
  int errors = 0;
  int mvld = 0;
  int midx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural model of the cores behind the window
  assign core_rdata = 32'h5A00_0000 | (32'(core_sel) << 20) | 32'(core_addr);

  win_switch_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_core(req_core), .req_we(req_we), .req_size(req_size), .req_off(req_off),
    .req_wdata(req_wdata), .req_fault(req_fault), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .core_en(core_en), .core_we(core_we),
    .core_sel(core_sel), .core_size(core_size), .core_addr(core_addr),
    .core_wdata(core_wdata), .core_rdata(core_rdata), .win_base(win_base)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] width_of(input logic [31:0] v, input int sz);
    if (sz == 0) return v & 32'h0000_00FF;
    if (sz == 1) return v & 32'h0000_FFFF;
    return v;
  endfunction

  task automatic do_req(input int core, input int we, input int sz, input int off,
                        input logic [31:0] wd, input int flt, input bit noise, input string tag);
    int lat;
    bit ok;
    bit hit;
    int en_cnt = 0;
    logic [31:0] seen_wd = '0;
    logic [31:0] exp_rd;
    logic got_err = 1'b0;
    logic [31:0] got_rd = '0;
    hit = (mvld != 0) && (midx == core);
    if (hit) begin
      lat = 1; ok = 1;
    end else if (flt >= MAXR + 2) begin
      lat = 2*(MAXR+2) + W*(MAXR+1); ok = 0;
    end else begin
      lat = 2*(flt+1) + W*flt + 1; ok = 1;
    end
    @(negedge clk);
    req_valid = 1'b1; req_core = 3'(core); req_we = we[0]; req_size = 2'(sz);
    req_off = RL'(off); req_wdata = wd; req_fault = 4'(flt);
    chk(req_ready == 1'b1, {tag, " R6 ready before accept"}, 32'(req_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    if (noise) req_core = 3'(core ^ 3);
    else req_valid = 1'b0;
    if (core_en) begin en_cnt++; seen_wd = core_wdata; end
    for (int n = 1; n <= lat + 1; n++) begin
      @(negedge clk);
      if (rsp_valid != (n == lat))
        chk(1'b0, {tag, " R3 R10 response timing"}, 32'(n), 32'(lat));
      if (n < lat && noise && req_ready)
        chk(1'b0, {tag, " R6 ready while busy"}, 32'(n), 32'd0);
      if (n == lat) begin
        got_err = rsp_err; got_rd = rsp_rdata;
        req_valid = 1'b0;
      end
      if (n < lat && core_en) begin en_cnt++; seen_wd = core_wdata; end
    end
    checks++;
    exp_rd = (we != 0) ? 32'd0 :
             ok ? width_of(32'h5A00_0000 | (32'(core) << 20) | 32'(off), sz)
                : width_of(32'hFFFF_FFFF, sz);
    chk(got_err == !ok, {tag, " R4 error flag"}, 32'(got_err), 32'(!ok));
    chk(got_rd == exp_rd, {tag, " R7 R4 response data"}, got_rd, exp_rd);
    chk(en_cnt == (ok ? 1 : 0), {tag, " R8 R4 core strobe count"}, 32'(en_cnt), 32'(ok ? 1 : 0));
    if (ok && we != 0)
      chk(seen_wd == wd, {tag, " R8 write data"}, seen_wd, wd);
    if (ok && !hit)
      chk(win_base == EBASE + (32'(core) << RL), {tag, " R1 window value"},
          win_base, EBASE + (32'(core) << RL));
    if (ok) begin mvld = 1; midx = core; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready after reset", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R9 no response after reset", 32'(rsp_valid), 32'd0);
    chk(win_base == EBASE, "R9 window reset value", win_base, EBASE);
    do_req(2, 0, 2, 12'h34C, 32'h0, 0, 1'b0, "first switch R9 R1");
    do_req(2, 0, 0, 12'h1F7, 32'h0, 0, 1'b0, "hit byte R2 R7");
    do_req(2, 1, 1, 12'h00A, 32'hDEAD_BEEF, 0, 1'b0, "hit write R8");
    do_req(5, 0, 1, 12'hABC, 32'h0, 2, 1'b1, "retry twice busy R3 R6");
    do_req(1, 0, 2, 12'h010, 32'h0, 5, 1'b0, "fail read R4");
    do_req(5, 0, 2, 12'h777, 32'h0, 0, 1'b0, "old core still mapped R5");
    do_req(3, 1, 0, 12'h100, 32'h1234_5678, 9, 1'b0, "fail write R4");
    do_req(1, 0, 0, 12'h0F0, 32'h0, 5, 1'b0, "fail byte read R4 R7");
    do_req(5, 0, 0, 12'h3C1, 32'h0, 7, 1'b0, "hit ignores fault R2");
    do_req(7, 0, 1, 12'h5A5, 32'h0, 4, 1'b0, "retry at limit R3");
    do_req(7, 1, 2, 12'h222, 32'hCAFE_F00D, 0, 1'b0, "hit write word R8");
    do_req(6, 0, 2, 12'hFFF, 32'h0, 1, 1'b1, "retry once busy R3 R6");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule